// File: doc/BRIEF.md
# Configurable Serial Frame Receiver

This block turns a single serial receive line back into data words. The frame format is chosen at run time: a low start bit, five to nine data bits sent least significant bit first, an optional even or odd parity bit, and one or two high stop bits. The same format settings drive the matching transmitter, so both ends of a link are set up from the same few configuration inputs.

Two timing modes are available. In asynchronous mode a single-cycle tick at sixteen times the bit rate paces the receiver. The receiver finds the falling edge of the start bit, confirms it half a bit later, and then samples each further bit at its centre. In synchronous mode a serial clock comes in alongside the data. Each bit is sampled on the serial-clock edge opposite to the one on which the transmitter changes its data. A polarity input picks which edge that is. Each received word appears on a 9-bit output together with a one-cycle valid strobe, a parity error flag and a framing error flag.

Top module: `serial_frame_rx`

## Requirements
- R1: After reset, `rx_valid`, `rx_data`, `parity_err` and `frame_err` are all zero.
- R2: `width_sel` picks the data width: 0 is 5 bits, 1 is 6, 2 is 7, 3 is 8, and 4 or above is 9. The first data bit received becomes bit 0 of `rx_data`. All bits above the configured width read zero.
- R3: With `par_en` high, one parity bit follows the data. `par_odd`=0 expects an even count of ones over the data and parity bits together; `par_odd`=1 expects an odd count. On a mismatch, `parity_err` is 1 in the same cycle as the `rx_valid` strobe. With `par_en` low, no parity bit is expected and `parity_err` is 0.
- R4: Only the first stop bit is examined. If it reads low, `frame_err` is 1 with that word. After a low stop bit, the receiver ignores the line until it has seen it high, and only then accepts a new start bit.
- R5: In asynchronous mode (`sync_mode`=0), a low line seen on an `os_tick` begins start detection. The line must still be low 8 ticks later, at mid-bit, or the start is dropped as noise and no word is produced. Each later bit is sampled every 16 ticks after that point.
- R6: In synchronous mode (`sync_mode`=1), the start bit and every later bit are sampled on a `sck` edge. With `sck_pol`=0 that is the falling edge; with `sck_pol`=1 it is the rising edge. Data that changes shortly after the opposite edge is therefore received correctly.
- R7: A new start bit is accepted right after the first stop bit has been sampled. Frames sent back to back with one stop bit are all received. A second stop bit is simply treated as idle line.
- R8: `rx_valid` is high for exactly one clock per received word. `rx_data`, `parity_err` and `frame_err` change only in the cycle in which `rx_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_mode | input | 1 | 1 = sample on serial clock, 0 = oversampled asynchronous |
| sck_pol | input | 1 | Sampling edge in synchronous mode: 0 falling, 1 rising |
| width_sel | input | 3 | Data width code (0..4 for 5..9 bits) |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate (asynchronous mode) |
| sck | input | 1 | Serial clock (synchronous mode) |
| rxd | input | 1 | Serial receive line, idle high |
| rx_data | output | 9 | Received word, zero-extended |
| rx_valid | output | 1 | One-cycle strobe for a received word |
| parity_err | output | 1 | Parity mismatch for the current word |
| frame_err | output | 1 | First stop bit read low for the current word |

## Verification
Most state faults in this receiver move the bit position, so they show up at the ports one word later. A wrong bit counter or a wrong sampling phase makes `rx_data` shift or pick up stop or parity bits, and this is visible at the `rx_valid` strobe of the very next frame. A wrong parity accumulator or a stuck re-arm flag shows up either as a flipped flag on that word or as a missing or extra strobe. This can take up to one frame time plus the idle gap the bench leaves between frames. The synchronous tests delay the data by two clocks after the transmit edge, so sampling on the wrong `sck` edge corrupts the data of the first word received.

// File: rtl/serial_frame_rx.sv
module serial_frame_rx #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_mode,
  input  logic       sck_pol,
  input  logic [2:0] width_sel,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       os_tick,
  input  logic       sck,
  input  logic       rxd,
  output logic [8:0] rx_data,
  output logic       rx_valid,
  output logic       parity_err,
  output logic       frame_err
);

  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2 - 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} state_t;

  state_t          state;
  logic [1:0]      rxd_sync;
  logic [2:0]      sck_sync;
  logic [CW-1:0]   os_cnt;
  logic [3:0]      bit_idx;
  logic [8:0]      shreg;
  logic            par_acc;
  logic            par_bad;
  logic            armed;

  wire       rxd_s     = rxd_sync[1];
  wire       sck_rise  = sck_sync[1] & ~sck_sync[2];
  wire       sck_fall  = ~sck_sync[1] & sck_sync[2];
  wire       samp_edge = sck_pol ? sck_rise : sck_fall;
  wire [3:0] nbits     = (width_sel >= 3'd4) ? 4'd9 : {1'b0, width_sel} + 4'd5;
  wire       os_last   = (os_cnt == CW'(OSR - 1));
  wire       bit_step  = sync_mode ? samp_edge : (os_tick & os_last);
  wire [CW-1:0] os_next = os_last ? '0 : os_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      rxd_sync   <= 2'b11;
      sck_sync   <= 3'b000;
      os_cnt     <= '0;
      bit_idx    <= '0;
      shreg      <= '0;
      par_acc    <= 1'b0;
      par_bad    <= 1'b0;
      armed      <= 1'b0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      parity_err <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      rxd_sync <= {rxd_sync[0], rxd};
      sck_sync <= {sck_sync[1:0], sck};
      rx_valid <= 1'b0;

      if (state != S_IDLE && state != S_START && !sync_mode && os_tick)
        os_cnt <= os_next;

      case (state)
        S_IDLE: begin
          if (rxd_s) armed <= 1'b1;
          if (armed && !rxd_s) begin
            if (sync_mode && samp_edge) begin
              state   <= S_DATA;
              armed   <= 1'b0;
              bit_idx <= '0;
              par_acc <= 1'b0;
              par_bad <= 1'b0;
            end else if (!sync_mode && os_tick) begin
              state  <= S_START;
              armed  <= 1'b0;
              os_cnt <= '0;
            end
          end
        end

        S_START: begin
          if (os_tick) begin
            if (os_cnt == CW'(MID)) begin
              os_cnt <= '0;
              if (!rxd_s) begin
                state   <= S_DATA;
                bit_idx <= '0;
                par_acc <= 1'b0;
                par_bad <= 1'b0;
              end else begin
                state <= S_IDLE;
              end
            end else begin
              os_cnt <= os_cnt + 1'b1;
            end
          end
        end

        S_DATA: begin
          if (bit_step) begin
            shreg   <= {rxd_s, shreg[8:1]};
            par_acc <= par_acc ^ rxd_s;
            bit_idx <= bit_idx + 4'd1;
            if (bit_idx == nbits - 4'd1)
              state <= par_en ? S_PAR : S_STOP;
          end
        end

        S_PAR: begin
          if (bit_step) begin
            par_bad <= par_acc ^ rxd_s ^ par_odd;
            state   <= S_STOP;
          end
        end

        S_STOP: begin
          if (bit_step) begin
            rx_valid   <= 1'b1;
            rx_data    <= shreg >> (4'd9 - nbits);
            frame_err  <= ~rxd_s;
            parity_err <= par_en & par_bad;
            armed      <= rxd_s;
            state      <= S_IDLE;
          end
        end

        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/serial_frame_rx_chk.sv
module serial_frame_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] width_sel,
  input logic       par_en,
  input logic [8:0] rx_data,
  input logic       rx_valid,
  input logic       parity_err,
  input logic       frame_err
);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r8_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_data));

  a_r8_flags_held: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable({parity_err, frame_err}));

  a_r3_no_parity_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !par_en) |-> !parity_err);

  a_r2_zero_extended: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && width_sel < 3'd4) |-> ((rx_data >> ({1'b0, width_sel} + 4'd5)) == 9'd0));

endmodule

bind serial_frame_rx serial_frame_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .width_sel(width_sel), .par_en(par_en),
  .rx_data(rx_data), .rx_valid(rx_valid), .parity_err(parity_err), .frame_err(frame_err)
);

// File: tb/serial_frame_rx_bench.sv
module serial_frame_rx_bench;
  localparam int CLK_P   = 10;
  localparam int TDIV    = 4;
  localparam int BIT_CLK = 16 * TDIV;
  localparam int HALF    = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_mode = 1'b0;
  logic       sck_pol = 1'b0;
  logic [2:0] width_sel = 3'd3;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       os_tick;
  logic       sck = 1'b0;
  logic       rxd = 1'b1;
  logic [8:0] rx_data;
  logic       rx_valid;
  logic       parity_err;
  logic       frame_err;

  int checks = 0;
  int fails  = 0;
  int cap_n  = 0;
  logic [8:0] cap_data [8];
  logic       cap_pe   [8];
  logic       cap_fe   [8];
  logic [1:0] tick_cnt = '0;

  always #(CLK_P / 2) clk = ~clk;

  always @(posedge clk) tick_cnt <= tick_cnt + 2'd1;
  assign os_tick = (tick_cnt == 2'(TDIV - 1));

  serial_frame_rx u_serial_frame_rx (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .sck_pol(sck_pol),
    .width_sel(width_sel), .par_en(par_en), .par_odd(par_odd), .os_tick(os_tick),
    .sck(sck), .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid),
    .parity_err(parity_err), .frame_err(frame_err)
  );

  always @(negedge clk) begin
    if (rst_n && rx_valid && cap_n < 8) begin
      cap_data[cap_n] = rx_data;
      cap_pe[cap_n]   = parity_err;
      cap_fe[cap_n]   = frame_err;
      cap_n++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input logic sm, input logic pol, input int n, input logic pen, input logic podd);
    @(negedge clk);
    sync_mode = sm;
    sck_pol   = pol;
    sck       = pol;
    width_sel = 3'(n - 5);
    par_en    = pen;
    par_odd   = podd;
    rxd       = 1'b1;
    repeat (2 * BIT_CLK) @(negedge clk);
    cap_n = 0;
  endtask

  task automatic drive_bit(input logic b);
    if (sync_mode) begin
      sck = ~sck_pol;
      repeat (2) @(negedge clk);
      rxd = b;
      repeat (HALF - 2) @(negedge clk);
      sck = sck_pol;
      repeat (HALF) @(negedge clk);
    end else begin
      rxd = b;
      repeat (BIT_CLK) @(negedge clk);
    end
  endtask

  task automatic send_frame(input logic [8:0] d, input int n, input logic flip_par,
                            input logic stop_v, input int nstop);
    logic p;
    p = par_odd;
    for (int i = 0; i < n; i++) p ^= d[i];
    p ^= flip_par;
    drive_bit(1'b0);
    for (int i = 0; i < n; i++) drive_bit(d[i]);
    if (par_en) drive_bit(p);
    drive_bit(stop_v);
    for (int i = 1; i < nstop; i++) drive_bit(1'b1);
  endtask

  task automatic idle_gap();
    rxd = 1'b1;
    repeat (2 * BIT_CLK) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "rx_valid", rx_valid, 0);
    chk("R1", "rx_data", rx_data, 0);
    chk("R1", "parity_err", parity_err, 0);
    chk("R1", "frame_err", frame_err, 0);
  endtask

  task automatic t_widths();
    for (int n = 5; n <= 9; n++) begin
      logic [8:0] mask;
      mask = 9'h1FF >> (9 - n);
      set_cfg(1'b0, 1'b0, n, 1'b0, 1'b0);
      send_frame(9'h1A5 ^ 9'(n), n, 1'b0, 1'b1, 1);
      idle_gap();
      chk("R2", "word count", cap_n, 1);
      chk("R2", "zero-extended data", cap_data[0], (9'h1A5 ^ 9'(n)) & mask);
      chk("R3", "no parity error with parity off", cap_pe[0], 0);
    end
  endtask

  task automatic t_parity();
    for (int k = 0; k < 4; k++) begin
      logic podd, flip;
      podd = k[0];
      flip = k[1];
      set_cfg(1'b0, 1'b0, 8, 1'b1, podd);
      send_frame(9'h0B7, 8, flip, 1'b1, 1);
      idle_gap();
      chk("R3", "word count", cap_n, 1);
      chk("R3", "data", cap_data[0], 9'h0B7);
      chk("R3", "parity_err", cap_pe[0], int'(flip));
      chk("R4", "frame_err clear", cap_fe[0], 0);
    end
  endtask

  task automatic t_frame_err();
    set_cfg(1'b0, 1'b0, 7, 1'b0, 1'b0);
    send_frame(9'h05A, 7, 1'b0, 1'b0, 1);
    rxd = 1'b0;
    repeat (3 * BIT_CLK) @(negedge clk);
    idle_gap();
    send_frame(9'h033, 7, 1'b0, 1'b1, 1);
    idle_gap();
    chk("R4", "words after low stop and held-low line", cap_n, 2);
    chk("R4", "frame_err on bad stop", cap_fe[0], 1);
    chk("R4", "data with bad stop", cap_data[0], 9'h05A);
    chk("R4", "frame_err cleared", cap_fe[1], 0);
    chk("R4", "next word data", cap_data[1], 9'h033);
  endtask

  task automatic t_noise();
    set_cfg(1'b0, 1'b0, 8, 1'b0, 1'b0);
    rxd = 1'b0;
    repeat (3 * TDIV) @(negedge clk);
    rxd = 1'b1;
    repeat (12 * BIT_CLK) @(negedge clk);
    chk("R5", "short low pulse rejected", cap_n, 0);
    send_frame(9'h0C3, 8, 1'b0, 1'b1, 1);
    idle_gap();
    chk("R5", "frame after noise count", cap_n, 1);
    chk("R5", "frame after noise data", cap_data[0], 9'h0C3);
  endtask

  task automatic t_back_to_back();
    set_cfg(1'b0, 1'b0, 9, 1'b1, 1'b0);
    send_frame(9'h1F0, 9, 1'b0, 1'b1, 1);
    send_frame(9'h00F, 9, 1'b0, 1'b1, 1);
    send_frame(9'h155, 9, 1'b0, 1'b1, 2);
    send_frame(9'h0AA, 9, 1'b1, 1'b1, 1);
    idle_gap();
    chk("R7", "back-to-back word count", cap_n, 4);
    chk("R7", "word 0", cap_data[0], 9'h1F0);
    chk("R7", "word 1", cap_data[1], 9'h00F);
    chk("R7", "word 2", cap_data[2], 9'h155);
    chk("R7", "word 3 after two stops", cap_data[3], 9'h0AA);
    chk("R3", "word 3 parity_err", cap_pe[3], 1);
    chk("R8", "word 1 parity_err", cap_pe[1], 0);
    chk("R8", "flags held after last word", parity_err, 1);
  endtask

  task automatic t_sync(input logic pol);
    set_cfg(1'b1, pol, 8, 1'b1, 1'b1);
    send_frame(9'h096, 8, 1'b0, 1'b1, 1);
    send_frame(9'h069, 8, 1'b1, 1'b1, 2);
    idle_gap();
    chk("R6", "sync word count", cap_n, 2);
    chk("R6", "sync word 0", cap_data[0], 9'h096);
    chk("R6", "sync word 0 parity", cap_pe[0], 0);
    chk("R6", "sync word 1", cap_data[1], 9'h069);
    chk("R6", "sync word 1 parity", cap_pe[1], 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_widths();
    t_parity();
    t_frame_err();
    t_noise();
    t_back_to_back();
    t_sync(1'b0);
    t_sync(1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule